// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration image into an FPGA whose configuration port takes one bit per clock. A single start pulse runs the whole sequence. The block holds the target's active-low program-request line low for a set time and then releases it. It waits for the target to report that it is ready to accept data. It then takes a requested number of bytes from a valid/ready byte stream and sends each one MSB first, with a configuration clock that it generates. After the last byte it keeps pulsing the clock until the target raises its done pin.

Each wait has a bound. If the target never reports ready, the run ends with an error. If done never appears after a bounded number of extra pulses, the run also ends with an error. If the byte source signals a fault, the load is cut short. A two-bit cause code tells the three failures apart. The success and error flags hold their value until the next start. The image itself comes from outside the block, already in byte form.

Top module: `cfgl_loader`

## Requirements
- R1: Out of reset and whenever idle, the block drives prog_n_o high, cclk_o low, cdata_o low, s_ready_o low, and busy_o, ok_o and err_o low.
- R2: A start pulse sampled while idle drives prog_n_o low for exactly HOLD_CYC clock cycles. After that, prog_n_o returns high and stays high for the rest of the run.
- R3: After release, the block polls init_n_i once per cycle and moves on once it is high. If init_n_i is still low after INIT_TMO polls, the run ends with err_o set, err_cause_o = 1, and no configuration clock pulse issued.
- R4: Bits are sent MSB first. cdata_o changes only while cclk_o is low and holds steady for the whole high phase, so the target samples on the rising edge.
- R5: Exactly byte_cnt_i bytes are shifted, which gives 8 × byte_cnt_i rising edges before the post-load phase. A count of zero skips the data phase.
- R6: s_ready_o is high only while the block waits for a byte, and cclk_o is low at that time. A byte moves when s_valid_i and s_ready_o are both high. If s_err_i is high while a byte is awaited, the load aborts with err_o set and err_cause_o = 3.
- R7: After the last byte, clock pulses continue until done_i is seen high while cclk_o is low. At that point the run ends with ok_o set and err_o clear. ok_o and err_o are never both high.
- R8: If done_i has not been seen after DONE_TMO post-load pulses, the run ends with err_o set and err_cause_o = 2.
- R9: Each high phase of cclk_o lasts exactly PHASE_CYC cycles. Inside a byte, consecutive rising edges are 2 × PHASE_CYC cycles apart.
- R10: busy_o is high from the cycle after the accepted start until the run ends. A start while busy is ignored. ok_o, err_o and err_cause_o hold their value until the next accepted start, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a configuration run (taken only when idle) |
| byte_cnt_i | input | CNT_W | Number of image bytes to send, latched at start |
| s_data_i | input | BYTE_W | Image byte from the source |
| s_valid_i | input | 1 | Source byte is valid |
| s_err_i | input | 1 | Source fault; aborts the load |
| s_ready_o | output | 1 | Block is ready to take a byte |
| init_n_i | input | 1 | Target init pin; high means ready for data |
| done_i | input | 1 | Target done pin, active high |
| prog_n_o | output | 1 | Program request to the target, active low |
| cclk_o | output | 1 | Configuration clock |
| cdata_o | output | 1 | Configuration data |
| busy_o | output | 1 | A run is in progress |
| ok_o | output | 1 | Last run ended with done seen |
| err_o | output | 1 | Last run ended in failure |
| err_cause_o | output | 2 | 0 none, 1 init timeout, 2 done timeout, 3 source abort |

## Verification
The bench builds the block with HOLD_CYC = 5, INIT_TMO = 8, DONE_TMO = 6 and PHASE_CYC = 2. With these values both timeouts and the program pulse can be reached and checked to the exact cycle in a few dozen cycles, where the defaults would take hundreds of thousands. Because PHASE_CYC is above one, the bench runs the counted phase variant and can tell a stretched or shortened clock phase apart from a correct one. A small target model in the bench captures bits on each rising edge of cclk_o. It drives the ready and done pins, so the bench can compare bytes, edge counts and failure causes.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_INIT,
      ST_FETCH,
      ST_SHIFT,
      ST_POST
   } cfgl_state_e;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_INIT = 2'd1,
      CAUSE_DONE = 2'd2,
      CAUSE_SRC  = 2'd3
   } cfgl_cause_e;

endpackage

// File: rtl/cfgl_timer.sv
// Loadable down counter shared by the hold, init-wait and post-load phases.
module cfgl_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i && cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfgl_shifter.sv
// Configuration clock generator and MSB-first byte shifter.
module cfgl_shifter #(
   parameter int BYTE_W    = 8,
   parameter int PHASE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              run_i,
   output logic              cclk_o,
   output logic              bit_o,
   output logic              pulse_end_o
);

   logic              high_q;
   logic              phase_last;
   logic [BYTE_W-1:0] sreg_q;

   generate
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("cfgl_shifter: PHASE_CYC must be at least 1");
      end
      if (PHASE_CYC == 1) begin : g_single
         assign phase_last = 1'b1;
      end else begin : g_counted
         localparam int PW = $clog2(PHASE_CYC);
         localparam logic [PW-1:0] LAST = PW'(PHASE_CYC - 1);
         logic [PW-1:0] pcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pcnt_q <= '0;
            end else if (!run_i || pcnt_q == LAST) begin
               pcnt_q <= '0;
            end else begin
               pcnt_q <= pcnt_q + PW'(1);
            end
         end
         assign phase_last = (pcnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_q <= 1'b0;
      end else if (!run_i) begin
         high_q <= 1'b0;
      end else if (phase_last) begin
         high_q <= ~high_q;
      end
   end

   assign pulse_end_o = run_i & high_q & phase_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
      end else if (load_i) begin
         sreg_q <= byte_i;
      end else if (pulse_end_o) begin
         sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
      end
   end

   assign cclk_o = high_q;
   assign bit_o  = sreg_q[BYTE_W-1];

endmodule

// File: rtl/cfgl_loader.sv
// Serial FPGA configuration sequencer: program pulse, init wait, byte
// shifting and post-load clocking until done.
module cfgl_loader
   import cfgl_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 24,
   parameter int HOLD_CYC  = 1200000,
   parameter int INIT_TMO  = 100000,
   parameter int DONE_TMO  = 100000,
   parameter int PHASE_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  byte_cnt_i,
   input  logic [BYTE_W-1:0] s_data_i,
   input  logic              s_valid_i,
   input  logic              s_err_i,
   output logic              s_ready_o,
   input  logic              init_n_i,
   input  logic              done_i,
   output logic              prog_n_o,
   output logic              cclk_o,
   output logic              cdata_o,
   output logic              busy_o,
   output logic              ok_o,
   output logic              err_o,
   output logic [1:0]        err_cause_o
);

   localparam int MAX_HI = (HOLD_CYC > INIT_TMO) ? HOLD_CYC : INIT_TMO;
   localparam int MAX_T  = (MAX_HI > DONE_TMO) ? MAX_HI : DONE_TMO;
   localparam int TW     = $clog2(MAX_T + 1);
   localparam int BW     = $clog2(BYTE_W);
   localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYC - 1);
   localparam logic [TW-1:0] INIT_LD = TW'(INIT_TMO - 1);
   localparam logic [TW-1:0] DONE_LD = TW'(DONE_TMO - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("cfgl_loader: BYTE_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("cfgl_loader: CNT_W must be at least 1");
      end
      if (HOLD_CYC < 1 || INIT_TMO < 1 || DONE_TMO < 1) begin : g_bad_time
         $error("cfgl_loader: hold and timeout counts must be at least 1");
      end
   endgenerate

   cfgl_state_e       state_q, state_d;
   logic [CNT_W-1:0]  rem_q;
   logic [BW-1:0]     bit_q;
   logic              ok_q, err_q;
   cfgl_cause_e       cause_q, cause_d;

   logic              t_load, t_dec, t_zero;
   logic [TW-1:0]     t_val;
   logic              sh_load, sh_run, sh_cclk, sh_bit, sh_end;
   logic              run_clr, set_ok, set_err;
   logic              bit_clr, bit_inc, rem_load, rem_dec;

   cfgl_timer #(.W(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (t_load),
      .load_val_i (t_val),
      .dec_i      (t_dec),
      .zero_o     (t_zero)
   );

   cfgl_shifter #(.BYTE_W(BYTE_W), .PHASE_CYC(PHASE_CYC)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (sh_load),
      .byte_i      (s_data_i),
      .run_i       (sh_run),
      .cclk_o      (sh_cclk),
      .bit_o       (sh_bit),
      .pulse_end_o (sh_end)
   );

   always_comb begin
      state_d  = state_q;
      cause_d  = CAUSE_NONE;
      t_load   = 1'b0;
      t_val    = '0;
      t_dec    = 1'b0;
      sh_load  = 1'b0;
      sh_run   = 1'b0;
      run_clr  = 1'b0;
      set_ok   = 1'b0;
      set_err  = 1'b0;
      bit_clr  = 1'b0;
      bit_inc  = 1'b0;
      rem_load = 1'b0;
      rem_dec  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d  = ST_PROG;
               t_load   = 1'b1;
               t_val    = HOLD_LD;
               run_clr  = 1'b1;
               rem_load = 1'b1;
            end
         end
         ST_PROG: begin
            if (t_zero) begin
               state_d = ST_INIT;
               t_load  = 1'b1;
               t_val   = INIT_LD;
            end else begin
               t_dec = 1'b1;
            end
         end
         ST_INIT: begin
            if (init_n_i) begin
               if (rem_q == '0) begin
                  state_d = ST_POST;
                  t_load  = 1'b1;
                  t_val   = DONE_LD;
               end else begin
                  state_d = ST_FETCH;
               end
            end else if (t_zero) begin
               state_d = ST_IDLE;
               set_err = 1'b1;
               cause_d = CAUSE_INIT;
            end else begin
               t_dec = 1'b1;
            end
         end
         ST_FETCH: begin
            if (s_err_i) begin
               state_d = ST_IDLE;
               set_err = 1'b1;
               cause_d = CAUSE_SRC;
            end else if (s_valid_i) begin
               state_d = ST_SHIFT;
               sh_load = 1'b1;
               bit_clr = 1'b1;
            end
         end
         ST_SHIFT: begin
            sh_run = 1'b1;
            if (sh_end) begin
               if (bit_q == BIT_LAST) begin
                  rem_dec = 1'b1;
                  if (rem_q == CNT_W'(1)) begin
                     state_d = ST_POST;
                     t_load  = 1'b1;
                     t_val   = DONE_LD;
                  end else begin
                     state_d = ST_FETCH;
                  end
               end else begin
                  bit_inc = 1'b1;
               end
            end
         end
         ST_POST: begin
            if (!sh_cclk && done_i) begin
               state_d = ST_IDLE;
               set_ok  = 1'b1;
            end else begin
               sh_run = 1'b1;
               if (sh_end) begin
                  if (t_zero) begin
                     state_d = ST_IDLE;
                     set_err = 1'b1;
                     cause_d = CAUSE_DONE;
                  end else begin
                     t_dec = 1'b1;
                  end
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rem_q   <= '0;
         bit_q   <= '0;
      end else begin
         state_q <= state_d;
         if (rem_load) begin
            rem_q <= byte_cnt_i;
         end else if (rem_dec) begin
            rem_q <= rem_q - CNT_W'(1);
         end
         if (bit_clr) begin
            bit_q <= '0;
         end else if (bit_inc) begin
            bit_q <= bit_q + BW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_q    <= 1'b0;
         err_q   <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else if (run_clr) begin
         ok_q    <= 1'b0;
         err_q   <= 1'b0;
         cause_q <= CAUSE_NONE;
      end else if (set_ok) begin
         ok_q <= 1'b1;
      end else if (set_err) begin
         err_q   <= 1'b1;
         cause_q <= cause_d;
      end
   end

   assign s_ready_o   = (state_q == ST_FETCH);
   assign prog_n_o    = (state_q != ST_PROG);
   assign cclk_o      = sh_cclk;
   assign cdata_o     = (state_q == ST_SHIFT) & sh_bit;
   assign busy_o      = (state_q != ST_IDLE);
   assign ok_o        = ok_q;
   assign err_o       = err_q;
   assign err_cause_o = cause_q;

endmodule

// File: rtl/cfgl_checker.sv
// Protocol checker for cfgl_loader, attached by bind.
module cfgl_checker #(
   parameter int PHASE_CYC = 1
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic prog_n_o,
   input logic cclk_o,
   input logic cdata_o,
   input logic s_ready_o,
   input logic ok_o,
   input logic err_o
);

   int unsigned hcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt_q <= 0;
      end else if (cclk_o) begin
         hcnt_q <= hcnt_q + 1;
      end else begin
         hcnt_q <= 0;
      end
   end

   a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (prog_n_o && !cclk_o && !cdata_o && !s_ready_o));

   a_r2_prog_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> busy_o);

   a_r4_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cclk_o && $past(cclk_o)) |-> $stable(cdata_o));

   a_r6_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> !cclk_o);

   a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_o && err_o));

   a_r9_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cclk_o |-> (hcnt_q < PHASE_CYC));

   a_r9_high_full: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cclk_o) |-> (hcnt_q == PHASE_CYC));

   a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (!ok_o && !err_o));

endmodule

bind cfgl_loader cfgl_checker #(.PHASE_CYC(PHASE_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .prog_n_o  (prog_n_o),
   .cclk_o    (cclk_o),
   .cdata_o   (cdata_o),
   .s_ready_o (s_ready_o),
   .ok_o      (ok_o),
   .err_o     (err_o)
);

// File: tb/tb_cfgl_loader.sv
module tb_cfgl_loader;

   localparam int CLK_PERIOD = 10;
   localparam int HOLD  = 5;
   localparam int INITT = 8;
   localparam int DONET = 6;
   localparam int PHASE = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] byte_cnt_i = '0;
   logic [7:0] s_data_i = '0;
   logic       s_valid_i = 1'b0;
   logic       s_err_i = 1'b0;
   logic       s_ready_o;
   logic       init_n_i = 1'b0;
   logic       done_i = 1'b0;
   logic       prog_n_o, cclk_o, cdata_o, busy_o, ok_o, err_o;
   logic [1:0] err_cause_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] mem [16];
   logic       bits [128];
   int rises, prog_lo, busy_cyc, min_gap, hi_min, hi_max;
   bit first_ok, first_err, hung;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgl_loader #(
      .BYTE_W(8), .CNT_W(8), .HOLD_CYC(HOLD), .INIT_TMO(INITT),
      .DONE_TMO(DONET), .PHASE_CYC(PHASE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
      .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_err_i(s_err_i),
      .s_ready_o(s_ready_o), .init_n_i(init_n_i), .done_i(done_i),
      .prog_n_o(prog_n_o), .cclk_o(cclk_o), .cdata_o(cdata_o),
      .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .err_cause_o(err_cause_o)
   );

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int byte_at(input int k);
      int v = 0;
      for (int b = 0; b < 8; b++) v = (v << 1) | int'(bits[k*8+b]);
      return v;
   endfunction

   // One configuration run with a target model and byte source in the loop.
   task automatic run(input int cnt, input int supply, input bit init_good,
                      input bit done_en, input int done_after, input int err_at,
                      input int restart_at);
      int idx = 0;
      int cyc = 0;
      int last_rise = -1;
      int hrun = 0;
      bit pend = 1'b0;
      bit prev_c = 1'b0;
      bit seen_busy = 1'b0;
      rises = 0; prog_lo = 0; busy_cyc = 0;
      min_gap = 1000; hi_min = 1000; hi_max = 0; hung = 1'b0;
      @(negedge clk);
      byte_cnt_i = 8'(cnt);
      init_n_i = 1'b0;
      done_i = 1'b0;
      start_i = 1'b1;
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc == 1) begin
            start_i = 1'b0;
            first_ok = ok_o;
            first_err = err_o;
         end
         start_i = (cyc == restart_at);
         if (pend) idx++;
         s_valid_i = (idx < supply);
         s_data_i  = mem[idx % 16];
         s_err_i   = (err_at >= 0) && (idx >= err_at);
         pend = s_valid_i && s_ready_o && !s_err_i;
         if (!prog_n_o) prog_lo++;
         init_n_i = init_good && prog_n_o && (prog_lo > 0);
         if (cclk_o && !prev_c) begin
            if (rises < 128) bits[rises] = cdata_o;
            rises++;
            if (last_rise >= 0 && cyc - last_rise < min_gap) min_gap = cyc - last_rise;
            last_rise = cyc;
         end
         if (cclk_o) hrun++;
         else if (prev_c) begin
            if (hrun < hi_min) hi_min = hrun;
            if (hrun > hi_max) hi_max = hrun;
            hrun = 0;
         end
         prev_c = cclk_o;
         done_i = done_en && (rises >= done_after);
         if (busy_o) begin
            busy_cyc++;
            seen_busy = 1'b1;
         end else if (seen_busy) begin
            break;
         end
         if (cyc > 4000) begin
            hung = 1'b1;
            break;
         end
      end
      s_valid_i = 1'b0;
      s_err_i = 1'b0;
      done_i = 1'b0;
      init_n_i = 1'b0;
      start_i = 1'b0;
      chk(!hung, "watchdog", int'(hung), 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(prog_n_o && !cclk_o && !cdata_o, "R1 pins in reset", {prog_n_o, cclk_o, cdata_o}, 3'b100);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy_o && !ok_o && !err_o && !s_ready_o, "R1 status idle",
          {busy_o, ok_o, err_o, s_ready_o}, 0);
      chk(prog_n_o && !cclk_o && !cdata_o, "R1 pins idle", {prog_n_o, cclk_o, cdata_o}, 3'b100);
   endtask

   task automatic t_normal;
      mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h81;
      run(3, 3, 1'b1, 1'b1, 27, -1, 30);
      chk(prog_lo == HOLD, "R2 program pulse", prog_lo, HOLD);
      chk(byte_at(0) == 'hA5, "R4 byte0 msb first", byte_at(0), 'hA5);
      chk(byte_at(1) == 'h3C, "R4 byte1", byte_at(1), 'h3C);
      chk(byte_at(2) == 'h81, "R4 byte2", byte_at(2), 'h81);
      chk(rises == 27, "R5 R7 total rises", rises, 27);
      chk(ok_o && !err_o && err_cause_o == 0, "R7 success flags", {ok_o, err_o}, 2'b10);
      chk(hi_min == PHASE && hi_max == PHASE, "R9 high phase", hi_max, PHASE);
      chk(min_gap == 2*PHASE, "R9 rise spacing", min_gap, 2*PHASE);
      repeat (4) @(negedge clk);
      chk(ok_o && !busy_o, "R10 ok held", ok_o, 1);
   endtask

   task automatic t_init_timeout;
      run(2, 2, 1'b0, 1'b1, 0, -1, 0);
      chk(first_ok == 0 && first_err == 0, "R10 flags cleared at start", first_ok, 0);
      chk(err_o && err_cause_o == 1, "R3 init timeout cause", err_cause_o, 1);
      chk(rises == 0, "R3 no clock", rises, 0);
      chk(busy_cyc == HOLD + INITT, "R3 poll window", busy_cyc, HOLD + INITT);
   endtask

   task automatic t_done_timeout;
      mem[0] = 8'h5A;
      run(1, 1, 1'b1, 1'b0, 0, -1, 0);
      chk(first_err == 0, "R10 err cleared at start", first_err, 0);
      chk(err_o && err_cause_o == 2, "R8 done timeout cause", err_cause_o, 2);
      chk(rises == 8 + DONET, "R8 pulse count", rises, 8 + DONET);
      chk(byte_at(0) == 'h5A, "R4 byte before timeout", byte_at(0), 'h5A);
   endtask

   task automatic t_src_abort;
      mem[0] = 8'hF0;
      run(4, 1, 1'b1, 1'b1, 40, 1, 0);
      chk(err_o && err_cause_o == 3, "R6 source abort cause", err_cause_o, 3);
      chk(rises == 8, "R6 R5 stopped early", rises, 8);
      chk(!ok_o, "R6 no success", ok_o, 0);
   endtask

   task automatic t_zero_count;
      run(0, 0, 1'b1, 1'b1, 0, -1, 0);
      chk(ok_o && !err_o, "R5 zero count success", ok_o, 1);
      chk(rises == 0, "R5 zero count no clock", rises, 0);
   endtask

   initial begin
      t_reset();
      t_normal();
      t_init_timeout();
      t_done_timeout();
      t_src_abort();
      t_zero_count();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule